// File: doc/BRIEF.md
# GPIO Bank with Per-Line Interrupt Sensing

This block is a bank of up to 32 general-purpose I/O lines controlled through a 32-bit register interface in APB style. Software sets each line as a general input, a general output, or an interrupt input. The pad side of the block has three ports: the output data, a per-line output enable, and the raw input pins. Raw pins pass through a two-stage synchroniser before any other logic uses them.

An interrupt line chooses three settings independently: its polarity, edge or level sensing, and single-edge or both-edge detection. Edge events are held in a status register until software writes ones to a separate clear address. Level events are not held; their status bit follows the qualified input. Enables are also set and cleared at different addresses: one address turns enables on with ones, and the enable register turns enables off with zeros. The block raises one combined interrupt output whenever an enabled line has status pending. Software then services the lowest pending bit first.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, no pad output enable is driven, and the interrupt output is low.
- R2: Bit n of every register refers to line n. pad_out equals the output data register (0x08). pad_oe is the direction bit (0x04, 1 = output) AND NOT the mode bit (0x00, 1 = interrupt input).
- R3: The input data register (0x0C) returns the pins after two synchronising flops.
- R4: An edge-sensed line (0x24 bit = 1) with polarity 0 (0x20) and both-edge 0 (0x4C) latches status (0x10) on a rising input. A falling input does not set it.
- R5: An edge-sensed line with polarity 1 latches status on a falling input only.
- R6: An edge-sensed line with both-edge 1 latches status on either transition, whatever its polarity.
- R7: A level-sensed line (0x24 bit = 0) shows status equal to the synchronised input XOR its polarity bit. This status is not latched, and a clear write does not remove it.
- R8: Writing a 1 to a bit at address 0x14 clears that latched edge status bit. Bits written as 0 leave their status bit unchanged.
- R9: Writing a 1 to a bit at 0x1C enables that line's interrupt. Writing 0x18 disables each bit written as 0 and keeps each bit written as 1. Reading 0x18 returns the enables, where 1 means enabled.
- R10: irq is high exactly when some line has both status and enable set.
- R11: A line in general mode never shows status, even if its input toggles.
- R12: When an edge event and a clear of the same bit reach the status register in the same cycle, the bit ends up set.
- R13: The polarity (0x20), sense (0x24), output-select (0x40) and both-edge (0x4C) registers read back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write |
| paddr | input | 8 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pad_in | input | 32 | Raw input pins |
| pad_out | output | 32 | Output data to pads |
| pad_oe | output | 32 | Per-line output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The only functions that can reach the same status bit in the same clock edge are a newly detected edge and a software clear. The bench provokes this on a both-edge line. It changes the pin exactly three clock edges before a clear write commits, so that the new event is latched on the edge where the clear arrives. The expected result is that status stays set. A clear-wins or last-writer ordering would show up as a zero in the status read that follows.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_MODE   = 8'h00,
    OFS_DIR    = 8'h04,
    OFS_DOUT   = 8'h08,
    OFS_DIN    = 8'h0C,
    OFS_STAT   = 8'h10,
    OFS_CLR    = 8'h14,
    OFS_EN     = 8'h18,
    OFS_UNMASK = 8'h1C,
    OFS_POL    = 8'h20,
    OFS_SENSE  = 8'h24,
    OFS_OSEL   = 8'h40,
    OFS_BOTH   = 8'h4C
  } reg_ofs_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  always_comb begin
    stage_d[0] = raw_i;
    for (int s = 1; s < STAGES; s++) stage_d[s] = stage_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= stage_d[s];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_sense.sv
module gpio_sense #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] sync_i,
  input  logic [LINES-1:0] mode_i,
  input  logic [LINES-1:0] pol_i,
  input  logic [LINES-1:0] sense_i,
  input  logic [LINES-1:0] both_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] status_o
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] latch_q, latch_d;
  logic [LINES-1:0] set_w;

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic rise_w, fall_w, hit_w;
    assign rise_w   = sync_i[n] & ~prev_q[n];
    assign fall_w   = ~sync_i[n] & prev_q[n];
    assign hit_w    = both_i[n] ? (rise_w | fall_w) : (pol_i[n] ? fall_w : rise_w);
    assign set_w[n] = mode_i[n] & sense_i[n] & hit_w;
    assign status_o[n] = mode_i[n] & (sense_i[n] ? latch_q[n] : (sync_i[n] ^ pol_i[n]));
  end

  // A new event outranks a simultaneous clear so that no edge is lost.
  always_comb latch_d = (latch_q & ~clr_i) | set_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= sync_i;
      latch_q <= latch_d;
    end
  end

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((latch_q & $past(clr_i & ~set_w)) == '0));

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w != '0) |=> ((latch_q & $past(set_w)) == $past(set_w)));
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [LINES-1:0]  din_i,
  input  logic [LINES-1:0]  status_i,
  output logic [LINES-1:0]  mode_o,
  output logic [LINES-1:0]  dir_o,
  output logic [LINES-1:0]  dout_o,
  output logic [LINES-1:0]  pol_o,
  output logic [LINES-1:0]  sense_o,
  output logic [LINES-1:0]  both_o,
  output logic [LINES-1:0]  irq_en_o,
  output logic [LINES-1:0]  clr_o
);
  logic [LINES-1:0] mode_q, dir_q, dout_q, pol_q, sense_q, both_q, osel_q, en_q;
  logic [LINES-1:0] mode_d, dir_d, dout_d, pol_d, sense_d, both_d, osel_d, en_d;
  logic [LINES-1:0] wval;
  logic wr_stb;
  logic we_mode, we_dir, we_dout, we_pol, we_sense, we_both, we_osel, we_en, we_unmask, we_clr;

  assign wr_stb = sel_i & en_i & wr_i;
  assign wval   = wdata_i[LINES-1:0];

  assign we_mode   = wr_stb && (addr_i == OFS_MODE);
  assign we_dir    = wr_stb && (addr_i == OFS_DIR);
  assign we_dout   = wr_stb && (addr_i == OFS_DOUT);
  assign we_pol    = wr_stb && (addr_i == OFS_POL);
  assign we_sense  = wr_stb && (addr_i == OFS_SENSE);
  assign we_both   = wr_stb && (addr_i == OFS_BOTH);
  assign we_osel   = wr_stb && (addr_i == OFS_OSEL);
  assign we_en     = wr_stb && (addr_i == OFS_EN);
  assign we_unmask = wr_stb && (addr_i == OFS_UNMASK);
  assign we_clr    = wr_stb && (addr_i == OFS_CLR);

  always_comb begin
    mode_d  = we_mode  ? wval : mode_q;
    dir_d   = we_dir   ? wval : dir_q;
    dout_d  = we_dout  ? wval : dout_q;
    pol_d   = we_pol   ? wval : pol_q;
    sense_d = we_sense ? wval : sense_q;
    both_d  = we_both  ? wval : both_q;
    osel_d  = we_osel  ? wval : osel_q;
    en_d    = en_q;
    if (we_en)     en_d = en_q & wval;
    if (we_unmask) en_d = en_q | wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; dir_q <= '0; dout_q <= '0; pol_q <= '0;
      sense_q <= '0; both_q <= '0; osel_q <= '0; en_q <= '0;
    end else if (wr_stb) begin
      mode_q <= mode_d; dir_q <= dir_d; dout_q <= dout_d; pol_q <= pol_d;
      sense_q <= sense_d; both_q <= both_d; osel_q <= osel_d; en_q <= en_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_MODE:  rdata_o[LINES-1:0] = mode_q;
      OFS_DIR:   rdata_o[LINES-1:0] = dir_q;
      OFS_DOUT:  rdata_o[LINES-1:0] = dout_q;
      OFS_DIN:   rdata_o[LINES-1:0] = din_i;
      OFS_STAT:  rdata_o[LINES-1:0] = status_i;
      OFS_EN:    rdata_o[LINES-1:0] = en_q;
      OFS_POL:   rdata_o[LINES-1:0] = pol_q;
      OFS_SENSE: rdata_o[LINES-1:0] = sense_q;
      OFS_OSEL:  rdata_o[LINES-1:0] = osel_q;
      OFS_BOTH:  rdata_o[LINES-1:0] = both_q;
      default:   rdata_o = '0;
    endcase
  end

  assign mode_o   = mode_q;
  assign dir_o    = dir_q;
  assign dout_o   = dout_q;
  assign pol_o    = pol_q;
  assign sense_o  = sense_q;
  assign both_o   = both_q;
  assign irq_en_o = en_q;
  assign clr_o    = we_clr ? wval : '0;

  assert_unmask_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_unmask |=> ((en_q & $past(wval)) == $past(wval)));

  assert_enable_zero_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_en |=> ((en_q & ~$past(wval)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned LINES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [BUS_W-1:0]  pwdata,
  output logic [BUS_W-1:0]  prdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  output logic              irq
);
  logic rst_meta_q, rst_core_n;
  logic [LINES-1:0] din_w, status_w, mode_w, dir_w, dout_w;
  logic [LINES-1:0] pol_w, sense_w, both_w, irq_en_w, clr_w;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  gpio_in_sync #(.WIDTH(LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .raw_i(pad_in), .sync_o(din_w)
  );

  gpio_regfile #(.LINES(LINES)) u_regs (
    .clk(clk), .rst_n(rst_core_n),
    .sel_i(psel), .en_i(penable), .wr_i(pwrite), .addr_i(paddr),
    .wdata_i(pwdata), .rdata_o(prdata),
    .din_i(din_w), .status_i(status_w),
    .mode_o(mode_w), .dir_o(dir_w), .dout_o(dout_w), .pol_o(pol_w),
    .sense_o(sense_w), .both_o(both_w), .irq_en_o(irq_en_w), .clr_o(clr_w)
  );

  gpio_sense #(.LINES(LINES)) u_sense (
    .clk(clk), .rst_n(rst_core_n), .sync_i(din_w), .mode_i(mode_w),
    .pol_i(pol_w), .sense_i(sense_w), .both_i(both_w), .clr_i(clr_w),
    .status_o(status_w)
  );

  assign pad_out = dout_w;
  assign pad_oe  = dir_w & ~mode_w;
  assign irq     = |(status_w & irq_en_w);

  assert_no_drive_on_irq_line_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(irq) |-> ((status_w & irq_en_w & mode_w) != '0));
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata, pad_in, pad_out, pad_oe;
  logic        irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic [31:0] cap;
  event cap_ev;

  always #4 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // Monitor: pops the expectation pushed by the driver and compares.
  initial forever begin
    item_t it;
    @(cap_ev);
    it = sb_q.pop_front();
    compared++;
    if (cap !== it.exp) begin
      mismatched++;
      $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, cap, it.exp);
    end
  end

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic exp_read(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1;
    push(0, exp, tag); cap = prdata; -> cap_ev;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic exp_port(int kind, logic [31:0] exp, string tag);
    @(negedge clk); #1;
    push(kind, exp, tag);
    case (kind)
      1: cap = {31'd0, irq};
      2: cap = pad_oe;
      default: cap = pad_out;
    endcase
    -> cap_ev;
  endtask

  task automatic drive_pins(logic [31:0] v);
    @(negedge clk); pad_in = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; pad_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    exp_read(8'h00, 32'h0, "R1 mode");
    exp_read(8'h04, 32'h0, "R1 dir");
    exp_read(8'h18, 32'h0, "R1 enable");
    exp_read(8'h10, 32'h0, "R1 status");
    exp_port(1, 32'h0, "R1 irq");
    exp_port(2, 32'h0, "R1 pad_oe");

    // R13 readback
    bus_write(8'h20, 32'h1234_5678); exp_read(8'h20, 32'h1234_5678, "R13 polarity");
    bus_write(8'h24, 32'hCAFE_0001); exp_read(8'h24, 32'hCAFE_0001, "R13 sense");
    bus_write(8'h40, 32'h0F0F_0F0F); exp_read(8'h40, 32'h0F0F_0F0F, "R13 outsel");
    bus_write(8'h4C, 32'h8000_0004); exp_read(8'h4C, 32'h8000_0004, "R13 both");
    bus_write(8'h20, 0); bus_write(8'h24, 0); bus_write(8'h40, 0); bus_write(8'h4C, 0);

    // R2 pad outputs
    bus_write(8'h04, 32'h0000_00FF);
    bus_write(8'h00, 32'h0000_000F);
    bus_write(8'h08, 32'hA5A5_A5A5);
    exp_port(2, 32'h0000_00F0, "R2 pad_oe");
    exp_port(3, 32'hA5A5_A5A5, "R2 pad_out");
    bus_write(8'h04, 0); bus_write(8'h00, 0);

    // R3 input data
    drive_pins(32'h8000_0001); settle();
    exp_read(8'h0C, 32'h8000_0001, "R3 din");
    drive_pins(32'h0); settle();
    exp_read(8'h0C, 32'h0, "R3 din low");

    // lines: 0 rise, 1 fall, 2 both, 3 level high, 4 level low
    bus_write(8'h20, 32'h12);
    bus_write(8'h24, 32'h07);
    bus_write(8'h4C, 32'h04);
    bus_write(8'h00, 32'h1F);
    bus_write(8'h14, 32'hFFFF_FFFF);
    exp_read(8'h10, 32'h10, "R7 level-low idle");

    // R4 rising
    drive_pins(32'h1); settle();
    exp_read(8'h10, 32'h11, "R4 rise latched");
    drive_pins(32'h0); settle();
    exp_read(8'h10, 32'h11, "R4 fall ignored");
    bus_write(8'h14, 32'h1);
    exp_read(8'h10, 32'h10, "R8 clear bit0");

    // R5 falling
    drive_pins(32'h2); settle();
    exp_read(8'h10, 32'h10, "R5 rise ignored");
    drive_pins(32'h0); settle();
    exp_read(8'h10, 32'h12, "R5 fall latched");
    bus_write(8'h14, 32'h0);
    exp_read(8'h10, 32'h12, "R8 zero write");
    bus_write(8'h14, 32'h2);
    exp_read(8'h10, 32'h10, "R8 clear bit1");

    // R6 both edges
    drive_pins(32'h4); settle();
    exp_read(8'h10, 32'h14, "R6 rise");
    bus_write(8'h14, 32'h4);
    drive_pins(32'h0); settle();
    exp_read(8'h10, 32'h14, "R6 fall");
    bus_write(8'h14, 32'h4);

    // R7 level
    drive_pins(32'h8); settle();
    exp_read(8'h10, 32'h18, "R7 level high");
    drive_pins(32'h18); settle();
    exp_read(8'h10, 32'h08, "R7 level low gone");
    drive_pins(32'h0); settle();
    exp_read(8'h10, 32'h10, "R7 not latched");
    bus_write(8'h14, 32'h10);
    exp_read(8'h10, 32'h10, "R7 clear no effect");

    // R11 general-mode line
    drive_pins(32'h20); settle();
    exp_read(8'h10, 32'h10, "R11 gen high");
    drive_pins(32'h0); settle();
    exp_read(8'h10, 32'h10, "R11 gen low");

    // R9 enable semantics
    bus_write(8'h1C, 32'h0000_00F0);
    exp_read(8'h18, 32'hF0, "R9 unmask");
    bus_write(8'h1C, 32'h0000_0001);
    exp_read(8'h18, 32'hF1, "R9 unmask zeros");
    bus_write(8'h18, 32'hFFFF_FF0F);
    exp_read(8'h18, 32'h01, "R9 enable write");

    // R10 combined irq
    exp_port(1, 32'h0, "R10 masked");
    bus_write(8'h1C, 32'h10);
    exp_port(1, 32'h1, "R10 level enabled");
    bus_write(8'h18, 32'hFFFF_FFEF);
    exp_port(1, 32'h0, "R10 disabled");
    drive_pins(32'h1); settle();
    exp_port(1, 32'h1, "R10 edge enabled");
    bus_write(8'h14, 32'h1);
    exp_port(1, 32'h0, "R10 after clear");
    drive_pins(32'h0); settle();

    // R12 event and clear in the same cycle
    drive_pins(32'h4); settle();
    exp_read(8'h10, 32'h14, "R12 pre");
    drive_pins(32'h0);
    bus_write(8'h14, 32'h4);
    exp_read(8'h10, 32'h14, "R12 set wins");
    bus_write(8'h14, 32'h4);
    exp_read(8'h10, 32'h10, "R12 clear after");

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule